// File: doc/BRIEF.md
# ECC Error Capture Status Register

This block sits beside a memory controller's ECC checker and records the first ECC event that the checker reports. The checker gives a one-cycle pulse for a corrected single-bit error or for an uncorrectable multi-bit error, along with the failing address and an 8-bit syndrome. The block keeps that first event in a 32-bit software-visible word. Software reads the word, handles the error, and then re-arms the block by clearing both event flags in a single write.

Three outputs come from the word. A non-maskable interrupt request is raised for a logged corrected error. A bus-error request is raised for a logged uncorrectable error. A scrub qualifier tells the read path whether a corrected read should be written back to memory. Each request has its own enable bit.

The register bus is a plain single-word port. A write strobe carries a full 32-bit word and is always accepted in the cycle it is asserted. Read data reflects the stored word at all times. The event inputs are level-sampled pulses, and they never stall: an event that arrives while the block is locked is consumed and dropped.

Top module: `ecc_err_log`

## Requirements
- R1: After reset the read word is all zero, nmi_req and berr_req are 0, and scrub_en is 1.
- R2: When no flag is set, a pulse on err_sbe alone sets bit 0 (single-bit flag). The same edge loads bits 30:12 with err_addr[30:12] and bits 11:4 with err_syn.
- R3: Bit 0 and bit 1 (multi-bit flag) are never both 1. If err_sbe and err_mbe pulse in the same cycle while no flag is set, only bit 1 is set.
- R4: While either flag is set, further error pulses are dropped. The address and syndrome fields keep their values. This also holds for an event that arrives in the same cycle as a clearing write.
- R5: Flags clear only when a write carries 1 in both bit 0 and bit 1. A write with only one of those bits at 1 leaves the flags unchanged.
- R6: Bits 31, 3 and 2 are loaded by every write. Writes never change bits 30:4.
- R7: nmi_req is high exactly when bit 0 and bit 2 (interrupt enable) are both 1. It falls in the cycle after the flag is cleared.
- R8: berr_req is high exactly when bit 1 and bit 3 (bus-error enable) are both 1.
- R9: scrub_en is the inverse of bit 31 (scrub disable).
- R10: After a clear, the next event is captured with its own address and syndrome.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| err_sbe | input | 1 | Corrected single-bit error pulse |
| err_mbe | input | 1 | Uncorrectable multi-bit error pulse |
| err_addr | input | 31 | Failing address of the event |
| err_syn | input | 8 | ECC syndrome of the event |
| bus_we | input | 1 | Register write strobe |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data |
| nmi_req | output | 1 | Interrupt request level for a logged corrected error |
| berr_req | output | 1 | Bus-error request level for a logged uncorrectable error |
| scrub_en | output | 1 | Write back corrected read data when high |

## Verification
The assertions check the following on every cycle:
- the two flags never both being set;
- the flag that wins when the block is unlocked, including a multi-bit error taking priority over a simultaneous single-bit error;
- the address, syndrome and flags holding steady while the block is locked and no full clear is written;
- the request and scrub outputs following the flag and enable bits.

Only the bench scenarios can show the following:
- that the captured fields hold the actual address bits and syndrome value;
- that writes leave the read-only fields untouched;
- that a half clear is refused while a full clear re-arms the block for a fresh capture;
- that an event coinciding with a clearing write is lost.

// File: rtl/ecc_log_pkg.sv
package ecc_log_pkg;
  // Software-controlled bits of the status word
  typedef struct packed {
    logic scrub_dis;
    logic berr_en;
    logic nmi_en;
  } ecc_ctrl_t;
endpackage

// File: rtl/ecc_log_capture.sv
module ecc_log_capture #(
  parameter int ADDR_W    = 31,
  parameter int ADDR_KEEP = 19,
  parameter int SYN_W     = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 err_sbe,
  input  logic                 err_mbe,
  input  logic [ADDR_W-1:0]    err_addr,
  input  logic [SYN_W-1:0]     err_syn,
  input  logic                 clr_both,
  output logic                 sbe_flag,
  output logic                 mbe_flag,
  output logic [ADDR_KEEP-1:0] addr_q,
  output logic [SYN_W-1:0]     syn_q
);
  localparam int DROP_W = ADDR_W - ADDR_KEEP;

  logic locked;
  logic addr_low_unused;

  assign locked          = sbe_flag | mbe_flag;
  assign addr_low_unused = ^err_addr[DROP_W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sbe_flag <= 1'b0;
      mbe_flag <= 1'b0;
      addr_q   <= '0;
      syn_q    <= '0;
    end else if (!locked) begin
      if (err_sbe || err_mbe) begin
        mbe_flag <= err_mbe;
        sbe_flag <= err_sbe & ~err_mbe;
        addr_q   <= err_addr[ADDR_W-1 -: ADDR_KEEP];
        syn_q    <= err_syn;
      end
    end else if (clr_both) begin
      sbe_flag <= 1'b0;
      mbe_flag <= 1'b0;
    end
  end
endmodule

// File: rtl/ecc_log_ctrl.sv
module ecc_log_ctrl
  import ecc_log_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      wr_en,
  input  ecc_ctrl_t wr_ctrl,
  input  logic      sbe_flag,
  input  logic      mbe_flag,
  output ecc_ctrl_t ctrl_q,
  output logic      nmi_req,
  output logic      berr_req,
  output logic      scrub_en
);
  always_ff @(posedge clk) begin
    if (!rst_n) ctrl_q <= '0;
    else if (wr_en) ctrl_q <= wr_ctrl;
  end

  assign nmi_req  = sbe_flag & ctrl_q.nmi_en;
  assign berr_req = mbe_flag & ctrl_q.berr_en;
  assign scrub_en = ~ctrl_q.scrub_dis;
endmodule

// File: rtl/ecc_err_log.sv
module ecc_err_log
  import ecc_log_pkg::*;
#(
  parameter int ADDR_W    = 31,
  parameter int ADDR_KEEP = 19,
  parameter int SYN_W     = 8
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                err_sbe,
  input  logic                                err_mbe,
  input  logic [ADDR_W-1:0]                   err_addr,
  input  logic [SYN_W-1:0]                    err_syn,
  input  logic                                bus_we,
  input  logic [SYN_W+ADDR_KEEP+4:0]          bus_wdata,
  output logic [SYN_W+ADDR_KEEP+4:0]          bus_rdata,
  output logic                                nmi_req,
  output logic                                berr_req,
  output logic                                scrub_en
);
  localparam int SBE_BIT   = 0;
  localparam int MBE_BIT   = 1;
  localparam int NMI_BIT   = 2;
  localparam int BERR_BIT  = 3;
  localparam int SYN_LSB   = 4;
  localparam int ADDR_LSB  = SYN_LSB + SYN_W;
  localparam int SCRUB_BIT = ADDR_LSB + ADDR_KEEP;
  localparam int REG_W     = SCRUB_BIT + 1;

  ecc_ctrl_t            wr_ctrl, ctrl_q;
  logic                 clr_both;
  logic                 sbe_flag, mbe_flag;
  logic [ADDR_KEEP-1:0] addr_q;
  logic [SYN_W-1:0]     syn_q;
  logic                 ro_wdata_unused;

  // A clear needs both flag bits written as 1 in one access
  assign clr_both = bus_we & bus_wdata[SBE_BIT] & bus_wdata[MBE_BIT];

  assign wr_ctrl.scrub_dis = bus_wdata[SCRUB_BIT];
  assign wr_ctrl.berr_en   = bus_wdata[BERR_BIT];
  assign wr_ctrl.nmi_en    = bus_wdata[NMI_BIT];
  assign ro_wdata_unused   = ^bus_wdata[SCRUB_BIT-1:SYN_LSB];

  ecc_log_capture #(
    .ADDR_W(ADDR_W), .ADDR_KEEP(ADDR_KEEP), .SYN_W(SYN_W)
  ) u_capture (
    .clk(clk), .rst_n(rst_n),
    .err_sbe(err_sbe), .err_mbe(err_mbe),
    .err_addr(err_addr), .err_syn(err_syn),
    .clr_both(clr_both),
    .sbe_flag(sbe_flag), .mbe_flag(mbe_flag),
    .addr_q(addr_q), .syn_q(syn_q)
  );

  ecc_log_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .wr_en(bus_we), .wr_ctrl(wr_ctrl),
    .sbe_flag(sbe_flag), .mbe_flag(mbe_flag),
    .ctrl_q(ctrl_q),
    .nmi_req(nmi_req), .berr_req(berr_req), .scrub_en(scrub_en)
  );

  always_comb begin
    bus_rdata                       = '0;
    bus_rdata[SCRUB_BIT]            = ctrl_q.scrub_dis;
    bus_rdata[SCRUB_BIT-1:ADDR_LSB] = addr_q;
    bus_rdata[ADDR_LSB-1:SYN_LSB]   = syn_q;
    bus_rdata[BERR_BIT]             = ctrl_q.berr_en;
    bus_rdata[NMI_BIT]              = ctrl_q.nmi_en;
    bus_rdata[MBE_BIT]              = mbe_flag;
    bus_rdata[SBE_BIT]              = sbe_flag;
  end
endmodule

// File: rtl/ecc_err_log_chk.sv
module ecc_err_log_chk #(
  parameter int REG_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             err_sbe,
  input logic             err_mbe,
  input logic             bus_we,
  input logic [1:0]       wdata_lo,
  input logic [REG_W-1:0] bus_rdata,
  input logic             nmi_req,
  input logic             berr_req,
  input logic             scrub_en
);
  logic locked, full_clr;
  assign locked   = bus_rdata[0] | bus_rdata[1];
  assign full_clr = bus_we & (wdata_lo == 2'b11);

  AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rdata[1:0] != 2'b11);                                           // R3
  AST_MBE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (!locked && err_mbe) |=> bus_rdata[1:0] == 2'b10);                  // R3
  AST_SBE_LOGS: assert property (@(posedge clk) disable iff (!rst_n)
    (!locked && err_sbe && !err_mbe) |=> bus_rdata[1:0] == 2'b01);      // R2
  AST_FIELDS_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && !full_clr) |=> $stable(bus_rdata[REG_W-2:0]) || bus_we); // R4
  AST_FLAGS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && !full_clr) |=> $stable(bus_rdata[1:0]));                 // R5
  AST_NMI_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_req == (bus_rdata[0] & bus_rdata[2]));                          // R7
  AST_BERR_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    berr_req == (bus_rdata[1] & bus_rdata[3]));                         // R8
  AST_SCRUB_QUAL: assert property (@(posedge clk) disable iff (!rst_n)
    scrub_en == !bus_rdata[REG_W-1]);                                   // R9
endmodule

bind ecc_err_log ecc_err_log_chk #(.REG_W(REG_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .err_sbe(err_sbe), .err_mbe(err_mbe),
  .bus_we(bus_we), .wdata_lo(bus_wdata[1:0]), .bus_rdata(bus_rdata),
  .nmi_req(nmi_req), .berr_req(berr_req), .scrub_en(scrub_en)
);

// File: tb/sim_ecc_err_log.sv
`timescale 1ns/1ps
module sim_ecc_err_log;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        err_sbe = 1'b0, err_mbe = 1'b0;
  logic [30:0] err_addr = '0;
  logic [7:0]  err_syn = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        nmi_req, berr_req, scrub_en;

  int total = 0, bad = 0;
  bit done = 1'b0;

  typedef struct {
    logic [31:0] rd;
    logic        nmi, berr, scrub;
    string       tag;
  } exp_t;
  exp_t q[$];

  always #10 clk = ~clk;

  ecc_err_log u0 (
    .clk(clk), .rst_n(rst_n), .err_sbe(err_sbe), .err_mbe(err_mbe),
    .err_addr(err_addr), .err_syn(err_syn), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .nmi_req(nmi_req), .berr_req(berr_req), .scrub_en(scrub_en)
  );

  // Expected word layout: {scrub_dis, addr[30:12], syn, berr_en, nmi_en, mbe, sbe}
  function automatic logic [31:0] mk(logic sd, logic [18:0] a, logic [7:0] s,
                                     logic be, logic ne, logic mb, logic sb);
    return {sd, a, s, be, ne, mb, sb};
  endfunction

  function automatic logic [31:0] wr(logic sd, logic be, logic ne, logic [1:0] clr);
    return {sd, 19'h5A5A5, 8'hC3, be, ne, clr};
  endfunction

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // Monitor: compare one expected item per falling edge
  initial begin
    forever begin
      @(negedge clk);
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        chk(e.tag, "rdata", bus_rdata, e.rd);
        chk(e.tag, "nmi_req", {31'b0, nmi_req}, {31'b0, e.nmi});
        chk(e.tag, "berr_req", {31'b0, berr_req}, {31'b0, e.berr});
        chk(e.tag, "scrub_en", {31'b0, scrub_en}, {31'b0, e.scrub});
      end
    end
  end

  // Driver: apply one cycle of stimulus, push the expected post-edge state
  task automatic step(logic sb, logic mb, logic [30:0] a, logic [7:0] s,
                      logic we, logic [31:0] wd, logic [31:0] exp_rd,
                      logic en, logic eb, logic es, string tag);
    exp_t e;
    err_sbe = sb; err_mbe = mb; err_addr = a; err_syn = s;
    bus_we = we; bus_wdata = wd;
    @(posedge clk);
    #1;
    err_sbe = 1'b0; err_mbe = 1'b0; bus_we = 1'b0;
    e.rd = exp_rd; e.nmi = en; e.berr = eb; e.scrub = es; e.tag = tag;
    q.push_back(e);
  endtask

  initial begin
    logic [30:0] a1, a2, a3, a4;
    a1 = 31'h1234_5000; a2 = 31'h7FED_C000; a3 = 31'h0ABC_D000; a4 = 31'h5555_5000;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1: reset state, idle cycle
    step(0, 0, '0, '0, 0, '0, 32'h0, 0, 0, 1, "R1");
    // R6 R9: controls load, read-only bits ignore written garbage
    step(0, 0, '0, '0, 1, wr(1, 1, 1, 2'b00), mk(1, '0, '0, 1, 1, 0, 0), 0, 0, 0, "R6_R9");
    step(0, 0, '0, '0, 1, wr(0, 1, 1, 2'b00), mk(0, '0, '0, 1, 1, 0, 0), 0, 0, 1, "R9");
    // R2 R7: single-bit error captured, interrupt raised
    step(1, 0, a1, 8'h3C, 0, '0, mk(0, a1[30:12], 8'h3C, 1, 1, 0, 1), 1, 0, 1, "R2_R7");
    // R4: later multi-bit event dropped
    step(0, 1, a2, 8'h99, 0, '0, mk(0, a1[30:12], 8'h3C, 1, 1, 0, 1), 1, 0, 1, "R4");
    // R5: half clear refused
    step(0, 0, '0, '0, 1, wr(0, 1, 1, 2'b01), mk(0, a1[30:12], 8'h3C, 1, 1, 0, 1), 1, 0, 1, "R5");
    step(0, 0, '0, '0, 1, wr(0, 1, 1, 2'b10), mk(0, a1[30:12], 8'h3C, 1, 1, 0, 1), 1, 0, 1, "R5");
    // R5 R7: full clear, interrupt drops, fields retained
    step(0, 0, '0, '0, 1, wr(0, 1, 1, 2'b11), mk(0, a1[30:12], 8'h3C, 1, 1, 0, 0), 0, 0, 1, "R5_R7");
    // R10 R8: fresh multi-bit capture with bus error
    step(0, 1, a2, 8'h99, 0, '0, mk(0, a2[30:12], 8'h99, 1, 1, 1, 0), 0, 1, 1, "R10_R8");
    // R4: event in the same cycle as a clear is lost
    step(1, 0, a3, 8'h11, 1, wr(0, 1, 1, 2'b11), mk(0, a2[30:12], 8'h99, 1, 1, 0, 0), 0, 0, 1, "R4");
    // R3: simultaneous events, multi-bit wins
    step(1, 1, a3, 8'h22, 0, '0, mk(0, a3[30:12], 8'h22, 1, 1, 1, 0), 0, 1, 1, "R3");
    // R8: bus-error enable off masks the request
    step(0, 0, '0, '0, 1, wr(0, 0, 1, 2'b11), mk(0, a3[30:12], 8'h22, 0, 1, 0, 0), 0, 0, 1, "R8");
    step(0, 1, a4, 8'h7E, 0, '0, mk(0, a4[30:12], 8'h7E, 0, 1, 1, 0), 0, 0, 1, "R8_R10");
    // R7: interrupt enable off masks the request
    step(0, 0, '0, '0, 1, wr(0, 0, 0, 2'b11), mk(0, a4[30:12], 8'h7E, 0, 0, 0, 0), 0, 0, 1, "R7");
    step(1, 0, a1, 8'h01, 0, '0, mk(0, a1[30:12], 8'h01, 0, 0, 0, 1), 0, 0, 1, "R7_R2");
    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (2000) @(posedge clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog expired: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule